// File: doc/BRIEF.md
# SCCB camera register master

This block drives the two-wire camera control bus (SCCB, close to I2C) so that software can program and read image-sensor registers. Software sets the SCL low and high durations in system-clock ticks, the number of bytes in a write transaction and the transaction kind. It places the device address, register address and up to two data bytes in a control word. A start command with its companion write-enable bit launches the transfer. The block then emits a start condition, the bytes MSB first with one acknowledge slot each, and a stop condition. Both lines are open-drain: the block only ever pulls them low or lets them go.

A sensor register read takes two separately started transactions. The first is a write-mode transaction that carries only the device and register address bytes. The second is a read-mode transaction: it sends the device address with its lowest bit set, clocks in one byte from the sensor, answers it with a NACK, and leaves the byte in the top byte of the configuration word. If the sensor does not acknowledge a byte, a sticky error flag is raised and the byte sequence still runs to its stop condition.

Register map (bus word address, 32-bit data). CFG at 0: [7:0] SCL low ticks, [15:8] SCL high ticks, [17:16] size code, [20] write mode, [31:24] received byte (read-only). CTL at 1: [7:0] device address, [15:8] register address, [23:16] first data byte, [31:24] second data byte. STS at 2: [0] go/busy, [1] go write-enable, [2] no-ACK error, [3] error write-enable.

Top module: `sccb_master`

## Requirements
- R1: After reset both lines are released (`scl_drive_low` = 0, `sda_drive_low` = 0), and CFG, CTL and STS all read as zero.
- R2: Each SCL low phase lasts CFG[7:0] clock cycles and each SCL high phase of a data bit lasts CFG[15:8] cycles; a value of 0 gives one cycle.
- R3: In write mode (CFG[20] = 1) the size code CFG[17:16] sets the byte count: 1 gives 2 bytes, 2 gives 3, 3 gives 4, and 0 gives 2. The bytes go out MSB first in the order device address (with bit 0 sent as 0), register address, CTL[23:16], CTL[31:24].
- R4: Each transfer begins with one start condition (SDA falls while SCL is high) and ends with one stop condition (SDA rises while SCL is high). Apart from these two, SDA never changes while SCL stays high.
- R5: A write to STS with bits 0 and 1 both set starts a transfer. STS[0] reads 1 while the transfer is running and 0 once it has ended. A write with bit 0 set and bit 1 clear starts nothing.
- R6: A start command given while a transfer is running is ignored. CTL is captured when the transfer starts, so later writes to CTL do not alter the bytes in flight.
- R7: In read mode (CFG[20] = 0) the transfer sends the device address with bit 0 sent as 1, then releases SDA for eight bits and samples them MSB first. It also keeps SDA released in the following acknowledge slot, which signals a NACK. The sampled byte appears in CFG[31:24] after the transfer.
- R8: In the acknowledge slot of every byte it sends, the block releases SDA. If SDA is high there, STS[2] is set, and the remaining bytes and the stop condition still follow.
- R9: STS[2] changes on a bus write only when STS bit 3 is written as 1, and it then takes the value of bit 2. A write with bit 3 clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The SCL-phase assertion assumes that CFG is not rewritten while a transfer is busy. The bench honours this by reprogramming timing, size and mode only after it has polled STS[0] back to 0. The acknowledge and data checks assume the sensor changes SDA only while SCL is low. The bench's sensor model therefore drives SDA half a clock after it has seen SCL fall, and releases it at the next SCL fall. Both the mid-transfer CTL rewrite and the repeated start command are issued well inside one transfer, so they fall within the busy window they are meant to test.

// File: rtl/sccb_pkg.sv
// Package: shared constants and types for the SCCB register master.
// Assumes a 32-bit register bus with word addresses.
package sccb_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned TICK_W = 8;
    localparam int unsigned BYTE_W = 8;

    localparam logic [ADDR_W-1:0] A_CFG = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTL = 2'd1;
    localparam logic [ADDR_W-1:0] A_STS = 2'd2;

    localparam int unsigned LO_LSB   = 0;
    localparam int unsigned HI_LSB   = 8;
    localparam int unsigned SIZE_LSB = 16;
    localparam int unsigned MODE_BIT = 20;
    localparam int unsigned RD_LSB   = 24;

    localparam int unsigned GO_BIT  = 0;
    localparam int unsigned GO_WE   = 1;
    localparam int unsigned ERR_BIT = 2;
    localparam int unsigned ERR_WE  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_STOP_REL
    } seq_state_t;

    typedef struct packed {
        logic [7:0] wd1;
        logic [7:0] wd0;
        logic [7:0] reg_addr;
        logic [7:0] dev;
    } xfer_t;
endpackage

// File: rtl/sccb_tick.sv
// Module: phase timer. A load starts a phase of max(len,1) cycles, and
// expire is high in the phase's last cycle. Assumes the caller reloads it
// in the cycle in which expire is seen.
module sccb_tick #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (len == '0) ? '0 : len - CNT_W'(1);
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/sccb_regs.sv
// Module: register file for CFG, CTL and STS. It issues the go pulse and
// holds the sticky no-ACK flag and the received byte. Assumes single-cycle
// bus writes and a combinational read port.
module sccb_regs
    import sccb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              nack_evt,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [TICK_W-1:0] lo_cnt,
    output logic [TICK_W-1:0] hi_cnt,
    output logic [1:0]        size_code,
    output logic              wr_mode,
    output xfer_t             xfer,
    output logic              go
);
    logic              wr_cfg, wr_ctl, wr_sts;
    logic              err_q;
    logic [BYTE_W-1:0] rd_q;
    wire               unused_wd = ^{bus_wdata[RD_LSB+7:MODE_BIT+1], bus_wdata[MODE_BIT-1:SIZE_LSB+2]};

    assign wr_cfg = bus_we && (bus_addr == A_CFG);
    assign wr_ctl = bus_we && (bus_addr == A_CTL);
    assign wr_sts = bus_we && (bus_addr == A_STS);
    assign go     = wr_sts && bus_wdata[GO_BIT] && bus_wdata[GO_WE] && !busy;

    // Hold the timing, size and mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt    <= '0;
            hi_cnt    <= '0;
            size_code <= '0;
            wr_mode   <= 1'b0;
        end else if (wr_cfg) begin
            lo_cnt    <= bus_wdata[LO_LSB +: TICK_W];
            hi_cnt    <= bus_wdata[HI_LSB +: TICK_W];
            size_code <= bus_wdata[SIZE_LSB +: 2];
            wr_mode   <= bus_wdata[MODE_BIT];
        end
    end

    // Hold the transaction bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            xfer <= '0;
        else if (wr_ctl)
            xfer <= xfer_t'(bus_wdata);
    end

    // Keep the byte received by the last read-mode transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rx_load)
            rd_q <= rx_byte;
    end

    // Sticky no-ACK flag: a masked write sets its value, a missed ACK sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (nack_evt)
            err_q <= 1'b1;
        else if (wr_sts && bus_wdata[ERR_WE])
            err_q <= bus_wdata[ERR_BIT];
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG: begin
                bus_rdata[LO_LSB +: TICK_W]   = lo_cnt;
                bus_rdata[HI_LSB +: TICK_W]   = hi_cnt;
                bus_rdata[SIZE_LSB +: 2]      = size_code;
                bus_rdata[MODE_BIT]           = wr_mode;
                bus_rdata[RD_LSB +: BYTE_W]   = rd_q;
            end
            A_CTL: bus_rdata = xfer;
            A_STS: begin
                bus_rdata[GO_BIT]  = busy;
                bus_rdata[ERR_BIT] = err_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R5/R6: the sequencer leaves idle only on an accepted go command.
    assert_busy_from_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    // R9: the flag rises only on a missed ACK or a masked write of 1.
    assert_err_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(nack_evt || (wr_sts && bus_wdata[ERR_WE] && bus_wdata[ERR_BIT])));

    // R9: the flag falls only on a masked write of 0.
    assert_err_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> $past(wr_sts && bus_wdata[ERR_WE] && !bus_wdata[ERR_BIT]));
endmodule

// File: rtl/sccb_seq.sv
// Module: bit sequencer. It runs start, bytes with acknowledge slots, and
// stop; it captures the read byte and flags missed ACKs. Assumes the timing
// fields are stable while busy. CTL is snapshotted at go.
module sccb_seq
    import sccb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [TICK_W-1:0] lo_cnt,
    input  logic [TICK_W-1:0] hi_cnt,
    input  logic [1:0]        size_code,
    input  logic              wr_mode,
    input  xfer_t             xfer,
    input  logic              sda_in,
    output logic              scl_low,
    output logic              sda_low,
    output logic              busy,
    output logic              nack_evt,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

    seq_state_t        state, state_n;
    xfer_t             snap;
    logic              rd_q;
    logic [1:0]        last_idx, byte_idx;
    logic [3:0]        bit_idx;
    logic [BYTE_W-1:0] sh, rx;
    logic              t_load, t_exp;
    logic [TICK_W-1:0] t_len;
    logic              rd_slot;
    wire               unused_dev0 = snap.dev[0];

    function automatic logic [BYTE_W-1:0] pick(input logic [1:0] idx, input xfer_t s, input logic rd);
        case (idx)
            2'd0:    pick = {s.dev[7:1], rd};
            2'd1:    pick = s.reg_addr;
            2'd2:    pick = s.wd0;
            default: pick = s.wd1;
        endcase
    endfunction

    sccb_tick #(.CNT_W(TICK_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expire(t_exp)
    );

    assign rd_slot = rd_q && (byte_idx == 2'd1);

    // Next phase and the timer length of that phase.
    always_comb begin
        state_n = state;
        t_load  = 1'b0;
        t_len   = hi_cnt;
        case (state)
            ST_IDLE:     if (go)    begin state_n = ST_START;  t_load = 1'b1; t_len = hi_cnt; end
            ST_START:    if (t_exp) begin state_n = ST_BIT_LO; t_load = 1'b1; t_len = lo_cnt; end
            ST_BIT_LO:   if (t_exp) begin state_n = ST_BIT_HI; t_load = 1'b1; t_len = hi_cnt; end
            ST_BIT_HI:   if (t_exp) begin
                t_load  = 1'b1;
                t_len   = lo_cnt;
                state_n = (bit_idx == ACK_SLOT && byte_idx == last_idx) ? ST_STOP_LO : ST_BIT_LO;
            end
            ST_STOP_LO:  if (t_exp) begin state_n = ST_STOP_HI;  t_load = 1'b1; t_len = hi_cnt; end
            ST_STOP_HI:  if (t_exp) begin state_n = ST_STOP_REL; t_load = 1'b1; t_len = hi_cnt; end
            ST_STOP_REL: if (t_exp) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // Phase register, transaction snapshot, byte and bit counters, shifters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            snap     <= '0;
            rd_q     <= 1'b0;
            last_idx <= '0;
            byte_idx <= '0;
            bit_idx  <= '0;
            sh       <= '0;
            rx       <= '0;
        end else begin
            state <= state_n;
            case (state)
                ST_IDLE: if (go) begin
                    snap     <= xfer;
                    rd_q     <= !wr_mode;
                    last_idx <= (!wr_mode || size_code == 2'd0) ? 2'd1 : size_code;
                end
                ST_START: if (t_exp) begin
                    byte_idx <= '0;
                    bit_idx  <= '0;
                    sh       <= pick(2'd0, snap, rd_q);
                end
                ST_BIT_HI: if (t_exp) begin
                    if (bit_idx != ACK_SLOT) begin
                        sh      <= {sh[BYTE_W-2:0], 1'b0};
                        bit_idx <= bit_idx + 4'd1;
                        if (rd_slot)
                            rx <= {rx[BYTE_W-2:0], sda_in};
                    end else begin
                        bit_idx <= '0;
                        if (byte_idx != last_idx) begin
                            byte_idx <= byte_idx + 2'd1;
                            sh       <= pick(byte_idx + 2'd1, snap, rd_q);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Line drive decoded from the phase and the current bit.
    always_comb begin
        case (state)
            ST_START, ST_STOP_LO, ST_STOP_HI: sda_low = 1'b1;
            ST_BIT_LO, ST_BIT_HI:
                sda_low = (bit_idx == ACK_SLOT || rd_slot) ? 1'b0 : !sh[BYTE_W-1];
            default: sda_low = 1'b0;
        endcase
    end

    assign scl_low  = (state == ST_BIT_LO) || (state == ST_STOP_LO);
    assign busy     = (state != ST_IDLE);
    assign nack_evt = (state == ST_BIT_HI) && t_exp && (bit_idx == ACK_SLOT) && !rd_slot && sda_in;
    assign rx_load  = (state == ST_STOP_REL) && t_exp && rd_q;
    assign rx_byte  = rx;

    // R4: with SCL high on both sides, SDA moves only for start and stop.
    assert_sda_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
            |-> (state == ST_START || state == ST_STOP_REL));

    // R8: SDA is released while the slave answers a sent byte.
    assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI && bit_idx == ACK_SLOT) |-> !sda_low);

    // R7: SDA is released for the whole received byte and its NACK slot.
    assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BIT_LO || state == ST_BIT_HI) && rd_q && byte_idx == 2'd1) |-> !sda_low);
endmodule

// File: rtl/sccb_master.sv
// Module: top of the SCCB register master, joining the register file and
// the bit sequencer. Assumes an external pull-up on both lines and no
// other master on the bus.
module sccb_master
    import sccb_pkg::*;
#(
    parameter int unsigned RUN_W = TICK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              sda_in
);
    logic [TICK_W-1:0] lo_cnt, hi_cnt;
    logic [1:0]        size_code;
    logic              wr_mode, go, busy, nack_evt, rx_load;
    logic [BYTE_W-1:0] rx_byte;
    xfer_t             xfer;
    logic [RUN_W-1:0]  low_run;

    sccb_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .nack_evt(nack_evt), .rx_load(rx_load), .rx_byte(rx_byte),
        .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .size_code(size_code),
        .wr_mode(wr_mode), .xfer(xfer), .go(go)
    );

    sccb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
        .size_code(size_code), .wr_mode(wr_mode), .xfer(xfer), .sda_in(sda_in),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low), .busy(busy),
        .nack_evt(nack_evt), .rx_load(rx_load), .rx_byte(rx_byte)
    );

    // Checker counter: length of the current SCL low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (scl_drive_low)
            low_run <= low_run + RUN_W'(1);
        else
            low_run <= '0;
    end

    // R2: every SCL low phase lasts the programmed number of ticks.
    assert_scl_low_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> (low_run == ((lo_cnt == '0) ? RUN_W'(1) : RUN_W'(lo_cnt))));
endmodule

// File: tb/tb_sccb_master.sv
// Bench: a sensor model on the open-drain lines; a scoreboard queue of
// expected bytes is filled by the driver and drained by the line monitor.
module tb_sccb_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        scl_drive_low, sda_drive_low;
    logic        slv_low = 1'b0;
    logic        scl_line, sda_line;

    assign scl_line = ~scl_drive_low;
    assign sda_line = ~(sda_drive_low | slv_low);

    always #10 clk = ~clk;

    sccb_master dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_in(sda_line)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Scoreboard.
    logic [7:0] exp_q[$];
    string      sb_tag = "R3";
    task automatic push_exp(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    // Sensor model and line monitor, sampled away from the active edge.
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    logic       in_frame = 1'b0, rd_txn = 1'b0, ack_en = 1'b1, master_ack = 1'b0;
    logic [7:0] cur = '0, rd_val = '0;
    int         bitn = 0, bytn = 0, starts = 0, stops = 0, frame_bytes = 0;
    int         run = 0, last_lo = 0, last_hi = 0;

    always @(negedge clk) begin
        if (scl_line == prev_scl) run++;
        else begin
            if (scl_line) last_lo = run; else last_hi = run;
            run = 1;
        end
        if (prev_scl && scl_line && prev_sda && !sda_line) begin
            starts++; in_frame = 1'b1; bitn = 0; bytn = 0; rd_txn = 1'b0;
        end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
            stops++; in_frame = 1'b0; frame_bytes = bytn;
        end else if (in_frame && !prev_scl && scl_line) begin
            if (bitn < 8) begin
                cur = {cur[6:0], sda_line};
                bitn++;
                if (bitn == 8) begin
                    if (bytn == 0) rd_txn = cur[0];
                    if (!(rd_txn && bytn == 1)) begin
                        if (exp_q.size() == 0) chk({sb_tag, " unexpected byte"}, cur, 'h100);
                        else chk({sb_tag, " byte order"}, cur, exp_q.pop_front());
                    end
                end
            end else begin
                if (rd_txn && bytn == 1) master_ack = sda_line;
                bitn = 0;
                bytn++;
            end
        end else if (in_frame && prev_scl && !scl_line) begin
            if (bitn == 8) slv_low = (rd_txn && bytn == 1) ? 1'b0 : ack_en;
            else if (rd_txn && bytn == 1) slv_low = ~rd_val[7 - bitn];
            else slv_low = 1'b0;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(2'd2, d);
            if (!d[0]) return;
        end
        chk({tag, " transfer never ended"}, 1, 0);
    endtask

    function automatic logic [31:0] cfg_word(input int lo, input int hi, input int sz, input bit wr);
        return (32'(wr) << 20) | (32'(sz) << 16) | (32'(hi) << 8) | 32'(lo);
    endfunction

    initial begin
        #(20 * 150000);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        #1;
        chk("R1 scl released", scl_drive_low, 0);
        chk("R1 sda released", sda_drive_low, 0);
        bus_rd(2'd0, d); chk("R1 CFG", d, 0);
        bus_rd(2'd1, d); chk("R1 CTL", d, 0);
        bus_rd(2'd2, d); chk("R1 STS", d, 0);

        // R3: 3-byte write, device bit 0 forced to 0; R5 busy; R2 timing; R4 framing.
        bus_wr(2'd0, cfg_word(4, 3, 2, 1));
        bus_wr(2'd1, {8'h00, 8'h5C, 8'h12, 8'h43});
        sb_tag = "R3";
        push_exp(8'h42); push_exp(8'h12); push_exp(8'h5C);
        s0 = starts;
        bus_wr(2'd2, 32'h3);
        bus_rd(2'd2, d); chk("R5 busy while running", d[0], 1);
        wait_idle("R5");
        chk("R3 all bytes sent", exp_q.size(), 0);
        chk("R4 one start", starts - s0, 1);
        chk("R4 one stop", stops - s0, 1);
        chk("R2 scl low ticks", last_lo, 4);
        chk("R2 scl high ticks", last_hi, 3);
        bus_rd(2'd2, d); chk("R8 no error when acked", d[2], 0);

        // R3: 4-byte write with 16-bit register address.
        bus_wr(2'd0, cfg_word(2, 5, 3, 1));
        bus_wr(2'd1, {8'hA7, 8'h34, 8'h30, 8'h78});
        push_exp(8'h78); push_exp(8'h30); push_exp(8'h34); push_exp(8'hA7);
        bus_wr(2'd2, 32'h3);
        wait_idle("R3");
        chk("R3 four bytes sent", exp_q.size(), 0);
        chk("R3 frame length 4", frame_bytes, 4);
        chk("R2 scl low ticks 2", last_lo, 2);
        chk("R2 scl high ticks 5", last_hi, 5);

        // R7: register read as address-only write then read transaction.
        bus_wr(2'd0, cfg_word(3, 3, 1, 1));
        bus_wr(2'd1, {8'hEE, 8'hDD, 8'h0A, 8'h42});
        push_exp(8'h42); push_exp(8'h0A);
        bus_wr(2'd2, 32'h3);
        wait_idle("R7");
        chk("R3 address phase 2 bytes", frame_bytes, 2);
        bus_wr(2'd0, cfg_word(3, 3, 3, 0));
        rd_val = 8'hA5;
        sb_tag = "R7";
        push_exp(8'h43);
        bus_wr(2'd2, 32'h3);
        wait_idle("R7");
        sb_tag = "R3";
        chk("R7 read frame 2 slots", frame_bytes, 2);
        chk("R7 master NACK", master_ack, 1);
        bus_rd(2'd0, d); chk("R7 received byte", d[31:24], 8'hA5);

        // R3: size code 0 gives 2 bytes; R2 zero counts give 1 tick.
        bus_wr(2'd0, cfg_word(0, 0, 0, 1));
        bus_wr(2'd1, {8'h00, 8'h11, 8'h99, 8'h20});
        push_exp(8'h20); push_exp(8'h99);
        bus_wr(2'd2, 32'h3);
        wait_idle("R3");
        chk("R3 code 0 frame 2 bytes", frame_bytes, 2);
        chk("R3 code 0 queue drained", exp_q.size(), 0);
        chk("R2 zero low gives 1", last_lo, 1);
        chk("R2 zero high gives 1", last_hi, 1);

        // R8: missing ACK is flagged, sequence completes.
        ack_en = 1'b0;
        bus_wr(2'd0, cfg_word(3, 2, 2, 1));
        bus_wr(2'd1, {8'h00, 8'h66, 8'h55, 8'h44});
        push_exp(8'h44); push_exp(8'h55); push_exp(8'h66);
        s0 = stops;
        bus_wr(2'd2, 32'h3);
        wait_idle("R8");
        ack_en = 1'b1;
        bus_rd(2'd2, d); chk("R8 error flag set", d[2], 1);
        chk("R8 all bytes still sent", frame_bytes, 3);
        chk("R8 stop still sent", stops - s0, 1);

        // R9: masked clear of the error flag.
        bus_wr(2'd2, 32'h0);
        bus_rd(2'd2, d); chk("R9 unmasked write keeps flag", d[2], 1);
        bus_wr(2'd2, 32'h8);
        bus_rd(2'd2, d); chk("R9 masked write clears flag", d[2], 0);

        // R5: go without its write-enable starts nothing.
        s0 = starts;
        bus_wr(2'd2, 32'h1);
        repeat (20) @(negedge clk);
        bus_rd(2'd2, d); chk("R5 no busy without enable", d[0], 0);
        chk("R5 no start without enable", starts - s0, 0);

        // R6: second go and CTL rewrite while busy are ignored.
        bus_wr(2'd1, {8'h00, 8'h3C, 8'h2B, 8'h1A});
        push_exp(8'h1A); push_exp(8'h2B); push_exp(8'h3C);
        s0 = starts;
        bus_wr(2'd2, 32'h3);
        repeat (5) @(negedge clk);
        bus_wr(2'd1, {8'h00, 8'hF3, 8'hF2, 8'hF0});
        bus_wr(2'd2, 32'h3);
        wait_idle("R6");
        repeat (60) @(negedge clk);
        chk("R6 single start", starts - s0, 1);
        chk("R6 snapshot bytes", exp_q.size(), 0);
        chk("R6 frame length", frame_bytes, 3);

        finish_run();
    end
endmodule